// File: doc/BRIEF.md
# Interrupt Steering Aggregator

The block gathers 160 level-sensitive system interrupt lines into three output lines for a single target processor. Lines are held in five banks of 32. Each bank has a mask word and a force word that software can write. It also has a status word that software can read. The status word is the live value (line AND mask) OR force. The status bits are ORed into three master groups of uneven size: 32, 64 and 64 lines. Each master output passes through a disable bit of its own and then through one register stage on the system clock.

Software reaches the block through a simple synchronous write port and a combinational read port, both byte-addressed on 32-bit words. Bank register index k covers the interrupt numbers from (4-k)*32 to (4-k)*32+31. The banks are therefore listed from the highest interrupt numbers down to the lowest.

Top module: `irq_steer_agg`

## Requirements
- R1: After reset, every mask, force and disable bit is zero, all three master outputs are low, and every register address reads zero.
- R2: Mask bank k is written and read at byte address 4*k (k = 0..4). Bit j of bank k is the mask for interrupt number (4-k)*32+j. A 1 lets the line through.
- R3: Force bank k is written and read at byte address 0x14+4*k, with the same bit mapping as R2. A 1 forces that status bit high.
- R4: Status bank k reads at byte address 0x28+4*k and returns (line AND mask) OR force for its 32 interrupts, taken live from the inputs. Writes to these addresses change no register and no output.
- R5: A line whose mask bit is 0 and whose force bit is 0 has no effect on any master output.
- R6: A set force bit drives its master output high even when the raw line is low and its mask bit is clear.
- R7: Master 0 is the OR of the status bits of interrupts 31..0. Master 1 is the OR over interrupts 95..32. Master 2 is the OR over interrupts 159..96.
- R8: The disable register at byte address 0x3C holds bit m, which forces master output m low when set. Bits 31..3 read as zero.
- R9: Each master output is registered once. It reflects the inputs and registers present at the previous rising clock edge.
- R10: An address above 0x3C or one that is not word aligned reads zero, and a write to it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 160 | System interrupt lines, bit n is interrupt number n |
| wr_en | input | 1 | Register write strobe, taken on the rising edge |
| addr | input | 8 | Byte address for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| master_irq | output | 3 | Registered master interrupt outputs |

## Verification
The bench targets the group edges at interrupts 31/32 and 95/96 and the ends at 0 and 159. A design that split the masters evenly, or that numbered the banks upward, would raise the wrong output at these points. Forcing a line with its input low and its mask clear catches a design that ANDs the force bit with the mask. Writes to the status and unmapped addresses, followed by readback, catch a decoder that aliases those addresses onto the mask or force words. Checking the output just before and just after the edge that follows a change catches a design with no output register or with two.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
    localparam int BANK_W      = 32;
    localparam int NUM_BANKS   = 5;
    localparam int NUM_MASTERS = 3;
    localparam int ADDR_W      = 8;

    // first interrupt number of master m: master 0 holds one bank, others two
    function automatic int master_lo(input int m, input int bw);
        return (m == 0) ? 0 : bw + (m - 1) * 2 * bw;
    endfunction

    function automatic int master_len(input int m, input int bw);
        return (m == 0) ? bw : 2 * bw;
    endfunction
endpackage

// File: rtl/irq_steer_regs.sv
module irq_steer_regs #(
    parameter int BANK_W      = irq_steer_pkg::BANK_W,
    parameter int NUM_BANKS   = irq_steer_pkg::NUM_BANKS,
    parameter int NUM_MASTERS = irq_steer_pkg::NUM_MASTERS,
    parameter int ADDR_W      = irq_steer_pkg::ADDR_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [BANK_W-1:0]             wdata,
    input  logic [NUM_BANKS*BANK_W-1:0]   status,
    output logic [NUM_BANKS*BANK_W-1:0]   mask,
    output logic [NUM_BANKS*BANK_W-1:0]   force_set,
    output logic [NUM_MASTERS-1:0]        mdis,
    output logic [BANK_W-1:0]             rdata
);
    localparam int LINES   = NUM_BANKS * BANK_W;
    localparam int WIDX_W  = ADDR_W - 2;
    localparam int SET_B   = NUM_BANKS;
    localparam int STAT_B  = 2 * NUM_BANKS;
    localparam int DIS_IDX = 3 * NUM_BANKS;

    typedef struct packed {
        logic [LINES-1:0]       mask;
        logic [LINES-1:0]       set;
        logic [NUM_MASTERS-1:0] dis;
    } regs_t;

    regs_t r_d, r_q;

    logic [WIDX_W-1:0] widx;
    logic              aligned;

    assign widx    = addr[ADDR_W-1:2];
    assign aligned = (addr[1:0] == 2'b00);

    always_comb begin
        r_d = r_q;
        if (wr_en && aligned) begin
            for (int k = 0; k < NUM_BANKS; k++) begin
                if (widx == WIDX_W'(k))
                    r_d.mask[(NUM_BANKS-1-k)*BANK_W +: BANK_W] = wdata;
                if (widx == WIDX_W'(SET_B + k))
                    r_d.set[(NUM_BANKS-1-k)*BANK_W +: BANK_W] = wdata;
            end
            if (widx == WIDX_W'(DIS_IDX))
                r_d.dis = wdata[NUM_MASTERS-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata = '0;
        if (aligned) begin
            for (int k = 0; k < NUM_BANKS; k++) begin
                if (widx == WIDX_W'(k))
                    rdata = r_q.mask[(NUM_BANKS-1-k)*BANK_W +: BANK_W];
                if (widx == WIDX_W'(SET_B + k))
                    rdata = r_q.set[(NUM_BANKS-1-k)*BANK_W +: BANK_W];
                if (widx == WIDX_W'(STAT_B + k))
                    rdata = status[(NUM_BANKS-1-k)*BANK_W +: BANK_W];
            end
            if (widx == WIDX_W'(DIS_IDX))
                rdata = {{(BANK_W-NUM_MASTERS){1'b0}}, r_q.dis};
        end
    end

    assign mask      = r_q.mask;
    assign force_set = r_q.set;
    assign mdis      = r_q.dis;
endmodule

// File: rtl/irq_steer_status.sv
module irq_steer_status #(
    parameter int BANK_W    = irq_steer_pkg::BANK_W,
    parameter int NUM_BANKS = irq_steer_pkg::NUM_BANKS
) (
    input  logic [NUM_BANKS*BANK_W-1:0] irq_in,
    input  logic [NUM_BANKS*BANK_W-1:0] mask,
    input  logic [NUM_BANKS*BANK_W-1:0] force_set,
    output logic [NUM_BANKS*BANK_W-1:0] status
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int LO = b * BANK_W;
        assign status[LO +: BANK_W] =
            (irq_in[LO +: BANK_W] & mask[LO +: BANK_W]) | force_set[LO +: BANK_W];
    end
endmodule

// File: rtl/irq_steer_master.sv
module irq_steer_master #(
    parameter int BANK_W      = irq_steer_pkg::BANK_W,
    parameter int NUM_BANKS   = irq_steer_pkg::NUM_BANKS,
    parameter int NUM_MASTERS = irq_steer_pkg::NUM_MASTERS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_BANKS*BANK_W-1:0] status,
    input  logic [NUM_MASTERS-1:0]      mdis,
    output logic [NUM_MASTERS-1:0]      master_irq
);
    typedef struct packed {
        logic [NUM_MASTERS-1:0] out;
    } mst_t;

    logic [NUM_MASTERS-1:0] grp;
    mst_t m_d, m_q;

    for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_grp
        localparam int LO  = irq_steer_pkg::master_lo(m, BANK_W);
        localparam int LEN = irq_steer_pkg::master_len(m, BANK_W);
        assign grp[m] = |status[LO +: LEN];
    end

    always_comb begin
        m_d.out = grp & ~mdis;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign master_irq = m_q.out;
endmodule

// File: rtl/irq_steer_agg.sv
module irq_steer_agg #(
    parameter int BANK_W      = irq_steer_pkg::BANK_W,
    parameter int NUM_BANKS   = irq_steer_pkg::NUM_BANKS,
    parameter int NUM_MASTERS = irq_steer_pkg::NUM_MASTERS,
    parameter int ADDR_W      = irq_steer_pkg::ADDR_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_BANKS*BANK_W-1:0]   irq_in,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [BANK_W-1:0]             wdata,
    output logic [BANK_W-1:0]             rdata,
    output logic [NUM_MASTERS-1:0]        master_irq
);
    localparam int LINES = NUM_BANKS * BANK_W;

    logic [LINES-1:0]       mask_w;
    logic [LINES-1:0]       set_w;
    logic [LINES-1:0]       status_w;
    logic [NUM_MASTERS-1:0] mdis_w;

    irq_steer_regs #(
        .BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS),
        .NUM_MASTERS(NUM_MASTERS), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .status(status_w), .mask(mask_w), .force_set(set_w), .mdis(mdis_w),
        .rdata(rdata)
    );

    irq_steer_status #(
        .BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS)
    ) u_status (
        .irq_in(irq_in), .mask(mask_w), .force_set(set_w), .status(status_w)
    );

    irq_steer_master #(
        .BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS), .NUM_MASTERS(NUM_MASTERS)
    ) u_master (
        .clk(clk), .rst_n(rst_n), .status(status_w), .mdis(mdis_w),
        .master_irq(master_irq)
    );
endmodule

// File: rtl/irq_steer_agg_chk.sv
module irq_steer_agg_chk #(
    parameter int BANK_W      = irq_steer_pkg::BANK_W,
    parameter int NUM_BANKS   = irq_steer_pkg::NUM_BANKS,
    parameter int NUM_MASTERS = irq_steer_pkg::NUM_MASTERS,
    parameter int ADDR_W      = irq_steer_pkg::ADDR_W
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          wr_en,
    input logic [ADDR_W-1:0]             addr,
    input logic [NUM_BANKS*BANK_W-1:0]   mask_w,
    input logic [NUM_BANKS*BANK_W-1:0]   set_w,
    input logic [NUM_BANKS*BANK_W-1:0]   status_w,
    input logic [NUM_MASTERS-1:0]        mdis_w,
    input logic [NUM_MASTERS-1:0]        master_irq
);
    localparam int STAT_LO = 8 * NUM_BANKS;
    localparam int STAT_HI = 12 * NUM_BANKS;
    localparam int MAP_END = 12 * NUM_BANKS + 4;

    logic stat_wr, unmapped_wr;
    assign stat_wr     = wr_en && (int'(addr) >= STAT_LO) && (int'(addr) < STAT_HI);
    assign unmapped_wr = wr_en && ((int'(addr) >= MAP_END) || (addr[1:0] != 2'b00));

    AST_DIS_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((master_irq & $past(mdis_w)) == '0)) else $error("dis"); // R8
    AST_STATUS_RO: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> ($stable(mask_w) && $stable(set_w) && $stable(mdis_w))) else $error("ro"); // R4
    AST_UNMAPPED_WR: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped_wr |=> ($stable(mask_w) && $stable(set_w) && $stable(mdis_w))) else $error("um"); // R10
    AST_FORCE_M0: assert property (@(posedge clk) disable iff (!rst_n)
        ((|set_w[BANK_W-1:0]) && !mdis_w[0]) |=> master_irq[0]) else $error("force"); // R6
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (status_w == '0) |=> (master_irq == '0)) else $error("idle"); // R5
    AST_ONE_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((|status_w[BANK_W-1:0]) && !mdis_w[0]) |=> master_irq[0]) else $error("lat"); // R9
endmodule

bind irq_steer_agg irq_steer_agg_chk #(
    .BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS),
    .NUM_MASTERS(NUM_MASTERS), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .mask_w(mask_w), .set_w(set_w), .status_w(status_w), .mdis_w(mdis_w),
    .master_irq(master_irq)
);

// File: tb/tb_irq_steer_agg.sv
module tb_irq_steer_agg;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 160;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [NL-1:0] irq_in = '0;
    logic         wr_en = 1'b0;
    logic [7:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic [2:0]   master_irq;

    logic [NL-1:0] m_mask = '0, m_set = '0;
    logic [2:0]    m_dis = '0;
    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_steer_agg dut (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .master_irq(master_irq));

    function automatic logic [31:0] exp_status(input int k);
        logic [NL-1:0] s = (irq_in & m_mask) | m_set;
        return s[(4-k)*32 +: 32];
    endfunction

    function automatic logic [2:0] exp_mout();
        logic [NL-1:0] s = (irq_in & m_mask) | m_set;
        logic [2:0] g = '0;
        for (int n = 0; n < NL; n++)
            if (s[n]) g[(n < 32) ? 0 : ((n < 96) ? 1 : 2)] = 1'b1;
        return g & ~m_dis;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        if (a[1:0] == 2'b00) begin
            if (a < 8'h14) m_mask[(4-a/4)*32 +: 32] = d;
            else if (a < 8'h28) m_set[(4-(a-8'h14)/4)*32 +: 32] = d;
            else if (a == 8'h3C) m_dis = d[2:0];
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic step_mout(input string req);
        @(posedge clk); @(negedge clk);
        chk(req, {29'd0, master_irq}, {29'd0, exp_mout()});
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'h1234ABCD));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 outputs", {29'd0, master_irq}, 32'd0);
        for (int a = 0; a < 16; a++) begin
            rd(8'(a*4), d); chk("R1 read", d, 32'd0);
        end
        // R5: unmasked-off lines ignored
        irq_in = '1;
        step_mout("R5 masked");
        chk("R5 none", {29'd0, master_irq}, 32'd0);
        irq_in = '0;
        // R2/R3: readback and bit mapping
        for (int k = 0; k < 5; k++) begin
            wr(8'(4*k), 32'hA5000000 | k);
            rd(8'(4*k), d); chk("R2 mask rb", d, 32'hA5000000 | k);
            wr(8'(8'h14 + 4*k), 32'h5A000000 | k);
            rd(8'(8'h14 + 4*k), d); chk("R3 set rb", d, 32'h5A000000 | k);
        end
        for (int k = 0; k < 5; k++) begin wr(8'(4*k), 0); wr(8'(8'h14 + 4*k), 0); end
        // R6: force with line low and mask clear
        wr(8'h24, 32'h20);
        step_mout("R6 force");
        chk("R6 m0", {29'd0, master_irq}, 32'd1);
        rd(8'h38, d); chk("R4 status force", d, 32'h20);
        wr(8'h24, 0);
        // R7: group edges via force bits on interrupts 0,31,32,95,96,159
        begin
            int ids[6] = '{0, 31, 32, 95, 96, 159};
            logic [2:0] em[6] = '{3'b001, 3'b001, 3'b010, 3'b010, 3'b100, 3'b100};
            for (int i = 0; i < 6; i++) begin
                wr(8'(8'h14 + 4*(4 - ids[i]/32)), 32'h1 << (ids[i] % 32));
                step_mout("R7 group");
                chk("R7 group exact", {29'd0, master_irq}, {29'd0, em[i]});
                wr(8'(8'h14 + 4*(4 - ids[i]/32)), 0);
            end
        end
        // R9: latency with real lines
        wr(8'h0C, 32'h8);                  // mask interrupt 35
        step_mout("R9 pre");
        irq_in[35] = 1'b1;
        #1 chk("R9 before edge", {29'd0, master_irq}, 32'd0);
        @(posedge clk); #1;
        chk("R9 after edge", {29'd0, master_irq}, 32'd2);
        @(negedge clk);
        rd(8'h34, d); chk("R4 status live", d, 32'h8);
        // R8: disable
        wr(8'h3C, 32'hFFFFFFFF);
        rd(8'h3C, d); chk("R8 dis rb", d, 32'h7);
        step_mout("R8 gated");
        chk("R8 all low", {29'd0, master_irq}, 32'd0);
        wr(8'h3C, 32'h5);
        step_mout("R8 partial");
        // R4: status writes ignored
        for (int k = 0; k < 5; k++) wr(8'(8'h28 + 4*k), 32'hFFFFFFFF);
        step_mout("R4 write ignored mout");
        rd(8'h0C, d); chk("R4 mask intact", d, 32'h8);
        rd(8'h20, d); chk("R4 set intact", d, 32'h0);
        // R10: unmapped and unaligned
        wr(8'h40, 32'hFFFFFFFF); wr(8'h01, 32'hFFFFFFFF); wr(8'hFC, 32'hFFFFFFFF);
        rd(8'h40, d); chk("R10 read hi", d, 0);
        rd(8'h01, d); chk("R10 read unaligned", d, 0);
        rd(8'h00, d); chk("R10 mask0 intact", d, 0);
        rd(8'h14, d); chk("R10 set0 intact", d, 0);
        step_mout("R10 mout");
        // random mix, R2 R3 R4 R7 R8 R9
        for (int it = 0; it < 300; it++) begin
            int act = $urandom_range(0, 3);
            int k = $urandom_range(0, 4);
            case (act)
                0: for (int w = 0; w < 5; w++) irq_in[w*32 +: 32] = $urandom & $urandom;
                1: wr(8'(4*k), $urandom);
                2: wr(8'(8'h14 + 4*k), (($urandom & $urandom) & $urandom) & $urandom);
                default: wr(8'h3C, $urandom);
            endcase
            step_mout("R7 random");
            rd(8'(8'h28 + 4*k), d); chk("R4 random status", d, exp_status(k));
        end
        finish_run();
    end
endmodule